// File: doc/BRIEF.md
# External Interrupt Polarity Normaliser

This block sits between two external interrupt pins and a downstream interrupt controller that only understands active-high levels and rising edges. Each pin is brought into the clock domain, cleaned by a programmable stability filter, and then turned into a normalised request according to its own configuration word. Level sources show up as an active-high level whatever their pin polarity. Edge sources show up as a one-cycle high pulse for each qualifying edge, whether that edge rises or falls. Software sets up each line through a small register bus and can see, per line, when the filter has settled after a configuration change.

The register bus is a plain control port. A write takes effect at the rising clock edge where `bus_sel` and `bus_we` are both high. Read data depends only on `bus_addr` and follows it without a clock. No stream data passes through the block, so there is no valid/ready handshake and no back-pressure. Pins and interrupt outputs are plain level signals.

Top module: `ext_irq_normaliser`

## Requirements
- R1: After reset both configuration words read as 0, the status word reads with both ready bits (bits 1:0) set to 1, and both interrupt outputs are low.
- R2: The status word is at byte offset 0x0, with bit n being the ready flag of line n. Line n's configuration word is at offset 0x4 + 4·n. In it, bit 16 is enable, bit 9 selects level (1) or edge (0) sensing, bit 8 is polarity, and bits 3:0 give the filter span F. Every other bit reads as 0, and written fields read back unchanged.
- R3: A read from any other offset, including misaligned ones, returns 0. A write to such an offset changes no configuration word.
- R4: While a line's enable bit is 0, its output stays low whatever the pin does and whatever the mode bits hold.
- R5: In level mode with polarity 1 (active-high), the output is high exactly while the filtered pin is high.
- R6: In level mode with polarity 0 (active-low), the output is high exactly while the filtered pin is low.
- R7: In edge mode with polarity 0, each rising edge of the filtered pin gives exactly one cycle of high output, and falling edges give none.
- R8: In edge mode with polarity 1, each falling edge of the filtered pin gives exactly one cycle of high output, and rising edges give none.
- R9: A pin change that is set up before clock edge 1 first shows at the output after clock edge 3+F. This covers two synchroniser stages and a filter that needs F+1 consecutive samples.
- R10: A pin pulse held for F clock edges or fewer never reaches the output. A pulse held for F+1 edges does reach it.
- R11: A write to line n's configuration word clears status bit n at that edge. The bit returns to 1 after the (F+1)-th edge that follows, where F is the value just written.
- R12: The two lines are independent. Activity or configuration on one line never changes the other line's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pin_i | input | NLINES | Asynchronous external interrupt pins |
| irq_o | output | NLINES | Normalised active-high requests, one per line |

## Verification
The hardest case to reach from the ports is the exact boundary of the stability filter. A pulse that lasts F edges must vanish, while one that lasts F+1 edges must pass. The case only shows up when the pin edges are placed at known points relative to the clock and every sample is counted through the two synchroniser flops. The bench therefore changes the pins only on falling clock edges and counts rising edges from that moment. It sweeps every line, all four modes and several filter spans, and predicts the exact cycle at which an output rises, pulses or falls: output edge 3+F. Separate pulses of length F and F+1 probe the boundary. The ready flag is timed the same way, from the write edge.

// File: rtl/ein_pkg.sv
`timescale 1ns/1ps
package ein_pkg;
  localparam int FLT_W      = 4;
  localparam int EN_BIT     = 16;
  localparam int LVL_BIT    = 9;
  localparam int POL_BIT    = 8;
  localparam int CFG_BASE   = 4;
  localparam int CFG_STRIDE = 4;

  typedef struct packed {
    logic             en;
    logic             lvl;
    logic             pol;
    logic [FLT_W-1:0] flt;
  } line_cfg_t;

  function automatic logic [31:0] cfg_pack(line_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[EN_BIT]      = c.en;
    w[LVL_BIT]     = c.lvl;
    w[POL_BIT]     = c.pol;
    w[FLT_W-1:0]   = c.flt;
    return w;
  endfunction

  function automatic line_cfg_t cfg_unpack(logic [31:0] w);
    line_cfg_t c;
    c.en  = w[EN_BIT];
    c.lvl = w[LVL_BIT];
    c.pol = w[POL_BIT];
    c.flt = w[FLT_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/ein_sync.sv
`timescale 1ns/1ps
module ein_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ein_filter.sv
`timescale 1ns/1ps
module ein_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] span,
  input  logic             cfg_wr,
  output logic             dout,
  output logic             ready
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] settle_q;
  logic             busy_q;

  // accept a new level after span+1 consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (din == dout) begin
      run_q <= '0;
    end else if (run_q >= span) begin
      dout  <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // settle window after a configuration write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      settle_q <= '0;
    end else if (cfg_wr) begin
      busy_q   <= 1'b1;
      settle_q <= '0;
    end else if (busy_q) begin
      if (settle_q >= span) busy_q <= 1'b0;
      else                  settle_q <= settle_q + 1'b1;
    end
  end

  assign ready = ~busy_q;
endmodule

// File: rtl/ein_sense.sv
`timescale 1ns/1ps
module ein_sense
  import ein_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      filt,
  input  line_cfg_t cfg,
  output logic      irq
);
  logic filt_q;
  logic rise, fall, edge_hit, lvl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= 1'b0;
    else        filt_q <= filt;
  end

  assign rise     = filt & ~filt_q;
  assign fall     = ~filt & filt_q;
  assign edge_hit = cfg.pol ? fall : rise;
  assign lvl_hit  = ~(filt ^ cfg.pol);
  assign irq      = cfg.en & (cfg.lvl ? lvl_hit : edge_hit);
endmodule

// File: rtl/ein_regs.sv
`timescale 1ns/1ps
module ein_regs
  import ein_pkg::*;
#(
  parameter int NLINES = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [NLINES-1:0]        ready_i,
  output line_cfg_t [NLINES-1:0]   cfg_o,
  output logic [NLINES-1:0]        cfg_wr_o,
  output logic [DATA_W-1:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] STAT_OFS = '0;

  logic [NLINES-1:0] hit;
  logic [31:0]       view [NLINES];
  logic [31:0]       wd32;

  assign wd32 = 32'(bus_wdata);

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CFG_BASE + n * CFG_STRIDE);
    line_cfg_t cfg_q;

    assign hit[n]      = (bus_addr == OFS);
    assign cfg_wr_o[n] = bus_sel & bus_we & hit[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cfg_q <= '0;
      else if (cfg_wr_o[n]) cfg_q <= cfg_unpack(wd32);
    end

    assign cfg_o[n] = cfg_q;
    assign view[n]  = cfg_pack(cfg_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_OFS) bus_rdata[NLINES-1:0] = ready_i;
    for (int n = 0; n < NLINES; n++) begin
      if (hit[n]) bus_rdata = DATA_W'(view[n]);
    end
  end
endmodule

// File: rtl/ext_irq_normaliser.sv
`timescale 1ns/1ps
module ext_irq_normaliser
  import ein_pkg::*;
#(
  parameter int NLINES      = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_i,
  output logic [NLINES-1:0] irq_o
);
  line_cfg_t [NLINES-1:0] cfg_w;
  logic [NLINES-1:0] cfg_wr_w;
  logic [NLINES-1:0] ready_w;
  logic [NLINES-1:0] sync_w;
  logic [NLINES-1:0] filt_w;
  logic [NLINES-1:0] en_w, lvl_w, pol_w;

  ein_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ready_i(ready_w),
    .cfg_o(cfg_w), .cfg_wr_o(cfg_wr_w), .bus_rdata(bus_rdata)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_chan
    assign en_w[n]  = cfg_w[n].en;
    assign lvl_w[n] = cfg_w[n].lvl;
    assign pol_w[n] = cfg_w[n].pol;

    ein_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_i[n]), .dout(sync_w[n])
    );

    ein_filter #(.CNT_W(FLT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(sync_w[n]), .span(cfg_w[n].flt),
      .cfg_wr(cfg_wr_w[n]), .dout(filt_w[n]), .ready(ready_w[n])
    );

    ein_sense u_sense (
      .clk(clk), .rst_n(rst_n), .filt(filt_w[n]), .cfg(cfg_w[n]), .irq(irq_o[n])
    );
  end
endmodule

// File: rtl/ext_irq_normaliser_chk.sv
`timescale 1ns/1ps
module ext_irq_normaliser_chk #(
  parameter int NLINES = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NLINES-1:0] irq_o,
  input logic [NLINES-1:0] en,
  input logic [NLINES-1:0] lvl,
  input logic [NLINES-1:0] pol,
  input logic [NLINES-1:0] filt,
  input logic [NLINES-1:0] ready,
  input logic [NLINES-1:0] cfg_wr
);
  logic unmapped;
  assign unmapped = (bus_addr[1:0] != 2'b00) ||
                    (int'(bus_addr) > NLINES * 4);

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0));

  for (genvar n = 0; n < NLINES; n++) begin : g_a
    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en[n] |-> !irq_o[n]);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en[n] && !lvl[n] && irq_o[n]) |=> (!irq_o[n] || lvl[n] || !$stable(pol[n])));

    assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en[n] && lvl[n] && $stable(filt[n]) && $stable(pol[n]) &&
       $stable(en[n]) && $stable(lvl[n])) |-> $stable(irq_o[n]));

    assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr[n] |=> !ready[n]);
  end
endmodule

bind ext_irq_normaliser ext_irq_normaliser_chk #(
  .NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .en(en_w), .lvl(lvl_w), .pol(pol_w), .filt(filt_w),
  .ready(ready_w), .cfg_wr(cfg_wr_w)
);

// File: tb/sim_ext_irq_normaliser.sv
`timescale 1ns/1ps
module sim_ext_irq_normaliser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pin = '0;
  logic [1:0]  irq;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ext_irq_normaliser u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pin), .irq_o(irq)
  );

  function automatic logic [31:0] cw(bit en, bit lv, bit po, int f);
    logic [31:0] w;
    w = '0;
    w[16] = en; w[9] = lv; w[8] = po; w[3:0] = 4'(f);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(4'h4, d); chk(d == 0, "R1 cfg0", d, 0);
    rd(4'h8, d); chk(d == 0, "R1 cfg1", d, 0);
    rd(4'h0, d); chk(d == 32'h3, "R1 status", d, 32'h3);
    chk(irq == 0, "R1 irq", 32'(irq), 0);

    // R2 field layout and readback
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk(d == 32'h0001_030F, "R2 all-ones readback", d, 32'h0001_030F);
    wr(4'h8, cw(1, 0, 1, 9));
    rd(4'h8, d); chk(d == cw(1, 0, 1, 9), "R2 cfg1 readback", d, cw(1, 0, 1, 9));

    // R3 unmapped offsets
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h2, 32'h0);
    rd(4'hC, d); chk(d == 0, "R3 read 0xC", d, 0);
    rd(4'h2, d); chk(d == 0, "R3 read 0x2", d, 0);
    rd(4'h4, d); chk(d == 32'h0001_030F, "R3 cfg0 untouched", d, 32'h0001_030F);
    rd(4'h8, d); chk(d == cw(1, 0, 1, 9), "R3 cfg1 untouched", d, cw(1, 0, 1, 9));
    wr(4'h4, 0); wr(4'h8, 0);
    idle(20);

    // R11 ready flag timing
    for (int f = 0; f < 7; f += 3) begin
      wr(4'h4, cw(0, 1, 1, f));
      rd(4'h0, d); chk(d[0] == 1'b0, "R11 ready low at write", d, 0);
      for (int j = 1; j <= f + 2; j++) begin
        @(negedge clk);
        rd(4'h0, d);
        chk(d[0] == (j >= f + 1), "R11 ready timing", 32'(d[0]), 32'(j >= f + 1));
      end
    end
    wr(4'h4, 0);

    // R5..R9 sweep of lines, modes and filter spans
    for (int ln = 0; ln < 2; ln++) begin
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 3; k++) begin
          automatic int  f   = (k == 0) ? 0 : (k == 1) ? 2 : 5;
          automatic bit  lv  = m[1];
          automatic bit  po  = m[0];
          automatic bit  tgt = lv ? po : ~po;
          automatic logic [3:0] a  = (ln == 0) ? 4'h4 : 4'h8;
          automatic logic [3:0] ao = (ln == 0) ? 4'h8 : 4'h4;
          automatic string tag = lv ? (po ? "R5 level-high" : "R6 level-low")
                                    : (po ? "R8 falling" : "R7 rising");
          wr(ao, 0);
          wr(a, cw(1, lv, po, f));
          pin[ln] = ~tgt;
          idle(f + 8);
          chk(irq == 0, {tag, " idle R12"}, 32'(irq), 0);
          pin[ln] = tgt;
          for (int j = 1; j <= f + 5; j++) begin
            automatic bit e;
            @(negedge clk);
            e = lv ? (j >= 3 + f) : (j == 3 + f);
            chk(irq == (2'(e) << ln), {tag, " assert R9"}, 32'(irq), 32'(2'(e) << ln));
          end
          pin[ln] = ~tgt;
          for (int j = 1; j <= f + 5; j++) begin
            automatic bit e;
            @(negedge clk);
            e = lv ? (j < 3 + f) : 1'b0;
            chk(irq == (2'(e) << ln), {tag, " release R9"}, 32'(irq), 32'(2'(e) << ln));
          end
        end
      end
    end

    // R4 disabled lines stay quiet in every mode
    for (int ln = 0; ln < 2; ln++) begin
      for (int m = 0; m < 4; m++) begin
        wr(4'h4, cw(0, m[1], m[0], 0));
        wr(4'h8, cw(0, m[1], m[0], 0));
        for (int j = 0; j < 12; j++) begin
          @(negedge clk);
          if (j % 3 == 0) pin[ln] = ~pin[ln];
          chk(irq == 0, "R4 disabled quiet", 32'(irq), 0);
        end
      end
    end

    // R10 glitch boundary, level-high, F=3
    wr(4'h8, 0);
    wr(4'h4, cw(1, 1, 1, 3));
    pin = 2'b00;
    idle(12);
    for (int len = 3; len <= 4; len++) begin
      automatic bit seen = 1'b0;
      pin[0] = 1'b1;
      for (int j = 1; j <= 12; j++) begin
        @(negedge clk);
        if (j == len) pin[0] = 1'b0;
        if (irq[0]) seen = 1'b1;
      end
      chk(seen == (len == 4), "R10 glitch boundary", 32'(seen), 32'(len == 4));
      idle(8);
    end

    // R12 two lines side by side
    wr(4'h4, cw(1, 1, 1, 0));
    wr(4'h8, cw(1, 1, 1, 0));
    pin = 2'b00;
    idle(6);
    pin[0] = 1'b1;
    idle(4);
    chk(irq == 2'b01, "R12 line0 only", 32'(irq), 1);
    pin[1] = 1'b1;
    idle(4);
    chk(irq == 2'b11, "R12 both", 32'(irq), 3);
    wr(4'h4, 0);
    idle(1);
    chk(irq == 2'b10, "R12 line1 kept", 32'(irq), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule